// File: doc/BRIEF.md
# DMA Engine Register Window

This block is the register window of one descriptor-driven DMA channel. Software reaches it over a plain 32-bit register bus with a byte address and a one-cycle write strobe; reads are combinational. The window holds a fixed capability word, a control and status word, three descriptor pointers and three activity counters. The engine core next to it reports what it is doing through single-cycle event strobes, busy and waiting levels, a byte count and descriptor addresses. The window returns an engine enable, a user-logic reset, a full engine reset and one interrupt line.

The control word drives a two-stage shutdown handshake. Software clears the interrupt enable. It then requests a user-logic reset, which holds until the core has been idle for a fixed number of cycles. It then requests a full reset, which runs for a fixed number of cycles and returns the window to its cleared state. Both request bits read back as 1 while their reset is in progress. Any leftover events are then acknowledged. Five event flags are write-1-to-clear, and together they feed the interrupt.

Top module: `dmaEngineRegs`

## Requirements
- R1: The word at byte offset 0x00 is read-only. Its bits are: 0 present, 1 direction (1 = card to system), 5:4 type (01 = packet), 15:8 engine number, 29:24 maximum buffer count. With the defaults it reads 0x14000313, and writes leave it unchanged.
- R2: After reset every word other than the capability word reads 0, and all four outputs are low.
- R3: Control word at 0x04. A strobe sets its flag: descriptor done sets bit 2, alignment error bit 3, fetch error bit 4, abort bit 5, chain end bit 7. Writing 1 to a flag bit clears it. A strobe in the same cycle as its clear leaves the flag set.
- R4: Bit 1 reads 1 while any flag is set. Writing 1 to bit 1 clears all flags.
- R5: Bit 0 is the interrupt enable. The interrupt output is high exactly when the enable is set and at least one flag is set.
- R6: Bit 8 is read/write and drives the engine enable output.
- R7: Bits 11:10 give the core state: 00 idle, 01 running (busy and not waiting), 10 waiting (waiting has priority).
- R8: Bit 12 is set in any cycle the core is waiting. It stays set until 1 is written to it.
- R9: Writing 1 to bit 14 starts a user-logic reset. The bit and the user reset output stay high until the core has been idle for 4 consecutive cycles, and then the bit clears.
- R10: Writing 1 to bit 15 raises the engine reset output for exactly 8 cycles. The bit reads 1 for that time. Control-word writes made meanwhile are ignored. On completion, flags, sticky bit, both enables, pointers and counters are 0, and the capability word is unchanged.
- R11: The word at 0x14 counts cycles spent running and the word at 0x18 counts cycles spent waiting. The word at 0x1C adds the reported byte count on each descriptor-done strobe.
- R12: The word at 0x0C is read/write for software. The word at 0x08 loads the core's next pointer when its load strobe is high. The word at 0x10 captures the core's current pointer on each descriptor-done strobe.
- R13: Writing 0 to bit 14 or 15 has no effect, and writes to the read-only words at 0x00 and 0x08 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W | Byte address inside the window |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for regAddr |
| evDescDone | input | 1 | Descriptor completed strobe |
| evAlignErr | input | 1 | Descriptor alignment error strobe |
| evFetchErr | input | 1 | Descriptor fetch error strobe |
| evAbort | input | 1 | Transfer aborted strobe |
| evChainEnd | input | 1 | End of descriptor chain strobe |
| coreBusy | input | 1 | Core is moving data |
| coreWaiting | input | 1 | Core is stalled waiting for descriptors |
| doneBytes | input | BYTE_W | Bytes moved by the completing descriptor |
| coreCurPtr | input | 32 | Address of the descriptor being completed |
| coreNextLoad | input | 1 | Load strobe for the next-descriptor pointer |
| coreNextPtr | input | 32 | Next descriptor address from the core |
| engEnable | output | 1 | Engine enable |
| userReset | output | 1 | User-logic reset, high during either reset |
| engReset | output | 1 | Full engine reset |
| irq | output | 1 | Interrupt for this engine |

## Verification
A bad internal reset counter shows first at the ports: the request bit or reset output drops a cycle early or late. That shows in the exact cycle the 4-cycle or 8-cycle window should end, so the bench samples on both sides of that edge. A flag register that loses an event, or misses a clear, shows on the interrupt line and in the control word one cycle after the strobe or write. A counter that steps in the wrong state gives a wrong value at its next read. The bench reads each counter after a known number of running and waiting cycles.

// File: rtl/dmaEngineRegs_pkg.sv
package dmaEngineRegs_pkg;
  // word indices within the window (byte offset / 4)
  localparam logic [5:0] IDX_CAP    = 6'd0;
  localparam logic [5:0] IDX_CSR    = 6'd1;
  localparam logic [5:0] IDX_HWNEXT = 6'd2;
  localparam logic [5:0] IDX_SWNEXT = 6'd3;
  localparam logic [5:0] IDX_LAST   = 6'd4;
  localparam logic [5:0] IDX_ACT    = 6'd5;
  localparam logic [5:0] IDX_WAIT   = 6'd6;
  localparam logic [5:0] IDX_BYTES  = 6'd7;

  // control-word bit positions that hold event flags
  localparam logic [7:0] EVENT_MASK = 8'hBC;
  localparam int NUM_TIMERS = 2;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'b00,
    ENG_RUN  = 2'b01,
    ENG_WAIT = 2'b10
  } engState_e;

  // control-word write fields, picked out of the bus data
  typedef struct packed {
    logic       intEnW;
    logic       ackAll;
    logic [5:0] evW1c;
    logic       engEnW;
    logic       waitedW1c;
    logic       userRstW;
    logic       fullRstW;
  } csrWrite_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       clrAll;
    logic [7:0] evClr;
    logic       waitedClr;
    logic       swPtrWr;
  } dpStrobe_t;
endpackage

// File: rtl/dmaRegCtrl.sv
module dmaRegCtrl
  import dmaEngineRegs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int USR_DLY  = 4,
  parameter int FULL_DLY = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  csrWrite_t         csrW,
  input  logic              coreIdle,
  output logic              intEn,
  output logic              engEn,
  output logic              userPend,
  output logic              fullPend,
  output dpStrobe_t         dpCtl
);
  localparam int UCW = $clog2(USR_DLY + 1);
  localparam int FCW = $clog2(FULL_DLY + 1);
  localparam int IW  = ADDR_W - 2;

  logic [UCW-1:0] usrCnt;
  logic [FCW-1:0] fullCnt;
  logic aligned, csrHit, swHit;

  assign aligned = (regAddr[1:0] == 2'b00);
  // control-word writes are locked out while the full reset runs
  assign csrHit  = wrEn && aligned && !fullPend &&
                   (regAddr[ADDR_W-1:2] == IW'(IDX_CSR));
  assign swHit   = wrEn && aligned && !fullPend &&
                   (regAddr[ADDR_W-1:2] == IW'(IDX_SWNEXT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn    <= 1'b0;
      engEn    <= 1'b0;
      userPend <= 1'b0;
      fullPend <= 1'b0;
      usrCnt   <= '0;
      fullCnt  <= '0;
    end else begin
      if (csrHit) begin
        intEn <= csrW.intEnW;
        engEn <= csrW.engEnW;
        if (csrW.userRstW && !userPend) begin
          userPend <= 1'b1;
          usrCnt   <= '0;
        end
        if (csrW.fullRstW) begin
          fullPend <= 1'b1;
          fullCnt  <= '0;
        end
      end
      // user reset: needs USR_DLY consecutive idle cycles
      if (userPend) begin
        if (!coreIdle) begin
          usrCnt <= '0;
        end else if (usrCnt == UCW'(USR_DLY - 1)) begin
          userPend <= 1'b0;
          usrCnt   <= '0;
        end else begin
          usrCnt <= usrCnt + UCW'(1);
        end
      end
      // full reset: fixed length, drops both enables at the end
      if (fullPend) begin
        if (fullCnt == FCW'(FULL_DLY - 1)) begin
          fullPend <= 1'b0;
          fullCnt  <= '0;
          intEn    <= 1'b0;
          engEn    <= 1'b0;
        end else begin
          fullCnt <= fullCnt + FCW'(1);
        end
      end
    end
  end

  always_comb begin
    dpCtl.clrAll    = fullPend;
    dpCtl.evClr     = '0;
    dpCtl.waitedClr = 1'b0;
    dpCtl.swPtrWr   = swHit;
    if (csrHit) begin
      dpCtl.evClr     = csrW.ackAll ? EVENT_MASK : ({csrW.evW1c, 2'b00} & EVENT_MASK);
      dpCtl.waitedClr = csrW.waitedW1c;
    end
  end
endmodule

// File: rtl/dmaRegData.sv
module dmaRegData
  import dmaEngineRegs_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 32,
  parameter int         BYTE_W      = 16,
  parameter bit         CAP_PRESENT = 1'b1,
  parameter bit         CAP_C2S     = 1'b1,
  parameter bit         CAP_PACKET  = 1'b1,
  parameter logic [7:0] ENG_NUM     = 8'd3,
  parameter logic [5:0] MAX_BC      = 6'd20
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dpCtl,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [7:0]        evIn,
  input  logic              coreBusy,
  input  logic              coreWaiting,
  input  logic [BYTE_W-1:0] doneBytes,
  input  logic              coreNextLoad,
  input  logic [DATA_W-1:0] coreNextPtr,
  input  logic [DATA_W-1:0] coreCurPtr,
  input  logic              intEn,
  input  logic              engEn,
  input  logic              userPend,
  input  logic              fullPend,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        evFlags,
  output logic              anyEvent
);
  localparam int IW = ADDR_W - 2;
  localparam logic [31:0] CAP_WORD = {2'b00, MAX_BC, 8'h00, ENG_NUM, 2'b00,
                                      1'b0, CAP_PACKET, 2'b00, CAP_C2S, CAP_PRESENT};

  engState_e         engState;
  logic              waited;
  logic [DATA_W-1:0] hwNext, swNext, lastDone, byteCnt;
  logic [DATA_W-1:0] timeCnt [NUM_TIMERS];
  logic [15:0]       csrWord;

  always_comb begin
    if (coreWaiting)   engState = ENG_WAIT;
    else if (coreBusy) engState = ENG_RUN;
    else               engState = ENG_IDLE;
  end

  // event flags: a new strobe wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             evFlags <= '0;
    else if (dpCtl.clrAll) evFlags <= '0;
    else                   evFlags <= ((evFlags & ~dpCtl.evClr) | evIn) & EVENT_MASK;
  end
  assign anyEvent = |evFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    waited <= 1'b0;
    else if (dpCtl.clrAll)        waited <= 1'b0;
    else if (engState == ENG_WAIT) waited <= 1'b1;
    else if (dpCtl.waitedClr)     waited <= 1'b0;
  end

  // one time counter per non-idle state
  for (genvar g = 0; g < NUM_TIMERS; g++) begin : gTimer
    localparam engState_e TRACKED = (g == 0) ? ENG_RUN : ENG_WAIT;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    timeCnt[g] <= '0;
      else if (dpCtl.clrAll)        timeCnt[g] <= '0;
      else if (engState == TRACKED) timeCnt[g] <= timeCnt[g] + DATA_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwNext   <= '0;
      swNext   <= '0;
      lastDone <= '0;
      byteCnt  <= '0;
    end else if (dpCtl.clrAll) begin
      hwNext   <= '0;
      swNext   <= '0;
      lastDone <= '0;
      byteCnt  <= '0;
    end else begin
      if (coreNextLoad)  hwNext <= coreNextPtr;
      if (dpCtl.swPtrWr) swNext <= wrData;
      if (evIn[2]) begin
        byteCnt  <= byteCnt + DATA_W'(doneBytes);
        lastDone <= coreCurPtr;
      end
    end
  end

  always_comb begin
    csrWord        = '0;
    csrWord[0]     = intEn;
    csrWord[1]     = anyEvent;
    csrWord[7:2]   = evFlags[7:2];
    csrWord[8]     = engEn;
    csrWord[11:10] = engState;
    csrWord[12]    = waited;
    csrWord[14]    = userPend;
    csrWord[15]    = fullPend;
  end

  always_comb begin
    rdData = '0;
    if (regAddr[1:0] == 2'b00) begin
      case (regAddr[ADDR_W-1:2])
        IW'(IDX_CAP):    rdData = DATA_W'(CAP_WORD);
        IW'(IDX_CSR):    rdData = DATA_W'(csrWord);
        IW'(IDX_HWNEXT): rdData = hwNext;
        IW'(IDX_SWNEXT): rdData = swNext;
        IW'(IDX_LAST):   rdData = lastDone;
        IW'(IDX_ACT):    rdData = timeCnt[0];
        IW'(IDX_WAIT):   rdData = timeCnt[1];
        IW'(IDX_BYTES):  rdData = byteCnt;
        default:         rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/dmaEngineRegs.sv
module dmaEngineRegs
  import dmaEngineRegs_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         BYTE_W      = 16,
  parameter int         USR_DLY     = 4,
  parameter int         FULL_DLY    = 8,
  parameter bit         CAP_PRESENT = 1'b1,
  parameter bit         CAP_C2S     = 1'b1,
  parameter bit         CAP_PACKET  = 1'b1,
  parameter logic [7:0] ENG_NUM     = 8'd3,
  parameter logic [5:0] MAX_BC      = 6'd20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              evDescDone,
  input  logic              evAlignErr,
  input  logic              evFetchErr,
  input  logic              evAbort,
  input  logic              evChainEnd,
  input  logic              coreBusy,
  input  logic              coreWaiting,
  input  logic [BYTE_W-1:0] doneBytes,
  input  logic [31:0]       coreCurPtr,
  input  logic              coreNextLoad,
  input  logic [31:0]       coreNextPtr,
  output logic              engEnable,
  output logic              userReset,
  output logic              engReset,
  output logic              irq
);
  csrWrite_t  csrW;
  dpStrobe_t  dpCtl;
  logic [7:0] evIn, evFlags;
  logic       intEn, engEn, userPend, fullPend, anyEvent, coreIdle;

  assign evIn = {evChainEnd, 1'b0, evAbort, evFetchErr, evAlignErr, evDescDone, 2'b00};

  assign csrW.intEnW    = wrData[0];
  assign csrW.ackAll    = wrData[1];
  assign csrW.evW1c     = wrData[7:2];
  assign csrW.engEnW    = wrData[8];
  assign csrW.waitedW1c = wrData[12];
  assign csrW.userRstW  = wrData[14];
  assign csrW.fullRstW  = wrData[15];

  assign coreIdle = !coreBusy && !coreWaiting;

  dmaRegCtrl #(
    .ADDR_W(ADDR_W), .USR_DLY(USR_DLY), .FULL_DLY(FULL_DLY)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .csrW(csrW),
    .coreIdle(coreIdle), .intEn(intEn), .engEn(engEn), .userPend(userPend),
    .fullPend(fullPend), .dpCtl(dpCtl)
  );

  dmaRegData #(
    .ADDR_W(ADDR_W), .DATA_W(32), .BYTE_W(BYTE_W), .CAP_PRESENT(CAP_PRESENT),
    .CAP_C2S(CAP_C2S), .CAP_PACKET(CAP_PACKET), .ENG_NUM(ENG_NUM), .MAX_BC(MAX_BC)
  ) data_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .regAddr(regAddr), .wrData(wrData),
    .evIn(evIn), .coreBusy(coreBusy), .coreWaiting(coreWaiting),
    .doneBytes(doneBytes), .coreNextLoad(coreNextLoad), .coreNextPtr(coreNextPtr),
    .coreCurPtr(coreCurPtr), .intEn(intEn), .engEn(engEn), .userPend(userPend),
    .fullPend(fullPend), .rdData(rdData), .evFlags(evFlags), .anyEvent(anyEvent)
  );

  assign irq       = intEn && anyEvent;
  assign engEnable = engEn;
  assign engReset  = fullPend;
  assign userReset = userPend || fullPend;
endmodule

// File: rtl/dmaEngineRegs_chk.sv
module dmaEngineRegs_chk #(
  parameter int FULL_DLY = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       irq,
  input logic       engReset,
  input logic [7:0] evIn,
  input logic [7:0] evFlags,
  input logic       fullPend,
  input logic       userPend,
  input logic       coreBusy,
  input logic       coreWaiting
);
  logic [7:0] highCyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         highCyc <= '0;
    else if (engReset) highCyc <= highCyc + 8'd1;
    else               highCyc <= '0;
  end

  // R10: full reset lasts exactly FULL_DLY cycles
  a_r10_full_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(engReset) |-> highCyc == 8'(FULL_DLY));

  // R10: the full reset never overruns its window
  a_r10_full_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    engReset |-> highCyc < 8'(FULL_DLY));

  // R10 and R5: nothing pending once the full reset is over
  a_r5_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $fell(engReset) |-> (!irq && evFlags == 8'h00));

  // R9: user reset only completes after the core was idle
  a_r9_user_after_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(userPend) |-> $past(!coreBusy && !coreWaiting));

  // R3: an event strobe is never lost
  a_r3_no_event_loss: assert property (@(posedge clk) disable iff (!rstN)
    (|evIn && !fullPend) |=> ((evFlags & $past(evIn)) == $past(evIn)));
endmodule

bind dmaEngineRegs dmaEngineRegs_chk #(.FULL_DLY(FULL_DLY)) chk_i (.*);

// File: tb/dmaEngineRegs_tb.sv
module dmaEngineRegs_tb_top;
  localparam int ADDR_W = 8;
  localparam int BYTE_W = 16;

  typedef struct {
    int          kind;   // 0 rdData, 1 irq, 2 engEnable, 3 userReset, 4 engReset
    logic [7:0]  addr;
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr, drvAddr = '0, monAddr = '0;
  logic              monActive = 1'b0;
  logic              wrEn = 1'b0;
  logic [31:0]       wrData = '0, rdData;
  logic              evDescDone = 1'b0, evAlignErr = 1'b0, evFetchErr = 1'b0;
  logic              evAbort = 1'b0, evChainEnd = 1'b0;
  logic              coreBusy = 1'b0, coreWaiting = 1'b0, coreNextLoad = 1'b0;
  logic [BYTE_W-1:0] doneBytes = '0;
  logic [31:0]       coreCurPtr = '0, coreNextPtr = '0;
  logic              engEnable, userReset, engReset, irq;

  assign regAddr = monActive ? monAddr : drvAddr;

  dmaEngineRegs dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .evDescDone(evDescDone), .evAlignErr(evAlignErr),
    .evFetchErr(evFetchErr), .evAbort(evAbort), .evChainEnd(evChainEnd),
    .coreBusy(coreBusy), .coreWaiting(coreWaiting), .doneBytes(doneBytes),
    .coreCurPtr(coreCurPtr), .coreNextLoad(coreNextLoad), .coreNextPtr(coreNextPtr),
    .engEnable(engEnable), .userReset(userReset), .engReset(engReset), .irq(irq)
  );

  item_t sbQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic expectItem(int kind, logic [7:0] addr, logic [31:0] mask,
                            logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.addr = addr; it.mask = mask; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // monitor: drains the scoreboard at each falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbQ.pop_front();
        monActive = 1'b1;
        monAddr   = it.addr;
        #1;
        case (it.kind)
          1:       act = {31'b0, irq};
          2:       act = {31'b0, engEnable};
          3:       act = {31'b0, userReset};
          4:       act = {31'b0, engReset};
          default: act = rdData & it.mask;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s addr %h actual %h expected %h", it.tag, it.addr, act, it.exp);
        end
      end
      monActive = 1'b0;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    wrEn = 1'b0; evDescDone = 1'b0; evAlignErr = 1'b0; evFetchErr = 1'b0;
    evAbort = 1'b0; evChainEnd = 1'b0; coreNextLoad = 1'b0;
  endtask

  task automatic setup();
    @(negedge clk); #9;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // ev bits: {chainEnd, abort, fetch, align, descDone}
  task automatic drive(bit doWr, logic [7:0] addr, logic [31:0] data, logic [4:0] ev);
    setup();
    if (doWr) begin drvAddr = addr; wrData = data; wrEn = 1'b1; end
    {evChainEnd, evAbort, evFetchErr, evAlignErr, evDescDone} = ev;
    tick();
  endtask

  task automatic wr(logic [7:0] addr, logic [31:0] data);
    drive(1'b1, addr, data, 5'b0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R2 reset state
    expectItem(0, 8'h04, 32'hFFFF_FFFF, 32'h0, "R2 csr");
    expectItem(0, 8'h14, 32'hFFFF_FFFF, 32'h0, "R2 active");
    expectItem(0, 8'h1C, 32'hFFFF_FFFF, 32'h0, "R2 bytes");
    expectItem(1, 8'h00, 32'h1, 32'h0, "R2 irq");
    expectItem(2, 8'h00, 32'h1, 32'h0, "R2 engEnable");
    expectItem(3, 8'h00, 32'h1, 32'h0, "R2 userReset");
    expectItem(4, 8'h00, 32'h1, 32'h0, "R2 engReset");
    expectItem(0, 8'h00, 32'hFFFF_FFFF, 32'h1400_0313, "R1 capability");
    cycles(1);

    // R3 R4 R5 flags and interrupt
    drive(1'b0, 8'h0, 32'h0, 5'b00010);
    expectItem(0, 8'h04, 32'hFF, 32'h0A, "R3 align flag");
    expectItem(1, 8'h00, 32'h1, 32'h0, "R5 irq masked");
    wr(8'h04, 32'h01);
    expectItem(1, 8'h00, 32'h1, 32'h1, "R5 irq enabled");
    drive(1'b0, 8'h0, 32'h0, 5'b10100);
    expectItem(0, 8'h04, 32'hFF, 32'h9B, "R3 fetch and chain flags");
    wr(8'h04, 32'h09);
    expectItem(0, 8'h04, 32'hFF, 32'h93, "R3 w1c align");
    drive(1'b1, 8'h04, 32'h11, 5'b00100);
    expectItem(0, 8'h04, 32'hFF, 32'h93, "R3 set wins over clear");
    wr(8'h04, 32'h03);
    expectItem(0, 8'h04, 32'hFF, 32'h01, "R4 ack clears all");
    expectItem(1, 8'h00, 32'h1, 32'h0, "R4 irq after ack");

    // R6 enable
    wr(8'h04, 32'h101);
    expectItem(2, 8'h00, 32'h1, 32'h1, "R6 engEnable");
    expectItem(0, 8'h04, 32'h1FF, 32'h101, "R6 csr");

    // R7 R8 R11 state and timers
    coreBusy = 1'b1;
    expectItem(0, 8'h04, 32'hC00, 32'h400, "R7 running");
    cycles(5);
    coreBusy = 1'b0; coreWaiting = 1'b1;
    expectItem(0, 8'h04, 32'hC00, 32'h800, "R7 waiting");
    cycles(3);
    coreWaiting = 1'b0;
    expectItem(0, 8'h04, 32'hC00, 32'h000, "R7 idle");
    expectItem(0, 8'h14, 32'hFFFF_FFFF, 32'd5, "R11 active time");
    expectItem(0, 8'h18, 32'hFFFF_FFFF, 32'd3, "R11 wait time");
    expectItem(0, 8'h04, 32'h1000, 32'h1000, "R8 waited sticky");
    cycles(2);
    expectItem(0, 8'h04, 32'h1000, 32'h1000, "R8 still sticky");
    wr(8'h04, 32'h1101);
    expectItem(0, 8'h04, 32'h1000, 32'h0, "R8 w1c");

    // R11 R12 byte count and pointers
    doneBytes = 16'd100; coreCurPtr = 32'h1000;
    drive(1'b0, 8'h0, 32'h0, 5'b00001);
    doneBytes = 16'd28; coreCurPtr = 32'h2000;
    drive(1'b0, 8'h0, 32'h0, 5'b00001);
    expectItem(0, 8'h1C, 32'hFFFF_FFFF, 32'd128, "R11 bytes");
    expectItem(0, 8'h10, 32'hFFFF_FFFF, 32'h2000, "R12 last done");
    expectItem(1, 8'h00, 32'h1, 32'h1, "R5 irq on done");
    wr(8'h0C, 32'hDEAD_0040);
    setup(); coreNextPtr = 32'h3000; coreNextLoad = 1'b1; tick();
    expectItem(0, 8'h0C, 32'hFFFF_FFFF, 32'hDEAD_0040, "R12 sw pointer");
    expectItem(0, 8'h08, 32'hFFFF_FFFF, 32'h3000, "R12 hw pointer");
    wr(8'h08, 32'h5555);
    wr(8'h00, 32'h0);
    expectItem(0, 8'h08, 32'hFFFF_FFFF, 32'h3000, "R13 hw pointer read-only");
    expectItem(0, 8'h00, 32'hFFFF_FFFF, 32'h1400_0313, "R13 capability read-only");

    // R9 user reset handshake
    coreBusy = 1'b1;
    wr(8'h04, 32'h4000);
    expectItem(3, 8'h00, 32'h1, 32'h1, "R9 userReset high");
    expectItem(0, 8'h04, 32'h4000, 32'h4000, "R9 bit set");
    expectItem(2, 8'h00, 32'h1, 32'h0, "R6 enable dropped");
    wr(8'h04, 32'h0);
    cycles(6);
    expectItem(0, 8'h04, 32'h4000, 32'h4000, "R13 zero write ignored, R9 busy holds");
    coreBusy = 1'b0;
    cycles(3);
    expectItem(0, 8'h04, 32'h4000, 32'h4000, "R9 third idle cycle");
    cycles(1);
    expectItem(0, 8'h04, 32'h4000, 32'h0, "R9 cleared");
    expectItem(3, 8'h00, 32'h1, 32'h0, "R9 userReset low");

    // R10 full reset
    wr(8'h04, 32'h8000);
    expectItem(4, 8'h00, 32'h1, 32'h1, "R10 engReset high");
    expectItem(0, 8'h04, 32'h8000, 32'h8000, "R10 bit set");
    wr(8'h04, 32'h101);
    cycles(6);
    expectItem(4, 8'h00, 32'h1, 32'h1, "R10 still in reset");
    cycles(1);
    expectItem(4, 8'h00, 32'h1, 32'h0, "R10 engReset done");
    expectItem(0, 8'h04, 32'hFFFF_FFFF, 32'h0, "R10 csr cleared");
    expectItem(2, 8'h00, 32'h1, 32'h0, "R10 write ignored");
    expectItem(0, 8'h14, 32'hFFFF_FFFF, 32'h0, "R10 active cleared");
    expectItem(0, 8'h1C, 32'hFFFF_FFFF, 32'h0, "R10 bytes cleared");
    expectItem(0, 8'h0C, 32'hFFFF_FFFF, 32'h0, "R10 sw pointer cleared");
    expectItem(0, 8'h08, 32'hFFFF_FFFF, 32'h0, "R10 hw pointer cleared");
    expectItem(0, 8'h00, 32'hFFFF_FFFF, 32'h1400_0313, "R10 capability kept");
    cycles(3);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule